// File: doc/BRIEF.md
# Private Interrupt Configuration Register Bank

This block holds the configuration and state bits for a bank of 32 private interrupts: the first 16 are software-generated and the rest are peripheral lines. Software reaches it over a single-cycle memory-mapped bus that carries byte and word accesses. Every access is tagged secure or non-secure. A global `sec_disable` input turns the secure/non-secure split off. While the split is active, a non-secure access sees only the interrupts whose group bit is set, and it sees their priorities through a shifted view.

The bank keeps the following state:

- enable, pending and active bitmaps, each reached through a set address and a clear address;
- a group bitmap and a group-modifier bitmap;
- a two-bit-per-SGI access-control word;
- an 8-bit priority per interrupt;
- an edge/level flag per interrupt, exposed as two trigger-configuration words.

The block also watches the live `line_level` inputs. Level-triggered lines show through in pending reads. A rising edge on an edge-triggered line latches its pending bit.

Register map (byte offsets, word registers):

| Offset | Register |
|---|---|
| 0x00 | group |
| 0x04 | enable set |
| 0x08 | enable clear |
| 0x0C | pending set |
| 0x10 | pending clear |
| 0x14 | active set |
| 0x18 | active clear |
| 0x1C | group modifier |
| 0x20 | SGI access control |
| 0x24 | trigger low (interrupts 0–15) |
| 0x28 | trigger high (interrupts 16–31) |
| 0x2C | identification |
| 0x40–0x5F | priority bytes, one per interrupt |

Top module: `irq_cfg_bank`

## Requirements
- R1: After reset every register reads zero and `rsp_valid` is low.
- R2: `req_ready` is high at all times. `rsp_valid` is high in the cycle after a read request and low in the cycle after a write or an idle cycle. `rsp_rdata` is registered in that same cycle.
- R3: A write to a set address ORs the permitted data bits into its bitmap. A write to a clear address clears them. A read of either address returns the same bitmap.
- R4: While `sec_disable` is 0, a non-secure access to the enable, pending, active or trigger words sees only bits whose group bit is 1. Other bits read 0 and are not changed by writes.
- R5: The group word reads 0 and ignores writes for a non-secure access while `sec_disable` is 0. Otherwise it is fully readable and writable.
- R6: The group-modifier word (0x1C) and the access-control word (0x20) read 0 and ignore writes unless the access is secure and `sec_disable` is 0.
- R7: A word access at 0x40+4n carries the priorities of interrupts 4n..4n+3, with the lowest-numbered interrupt in bits 7:0. A byte access at 0x40+i reads interrupt i's priority in bits 7:0 and writes it from `req_wdata[7:0]`.
- R8: For a non-secure priority access while `sec_disable` is 0, fields of group-0 interrupts read 0 and ignore writes. For group-1 interrupts a read returns (stored << 1) truncated to 8 bits, and a write stores 0x80 | (data >> 1).
- R9: Bit 2k+1 of the trigger-high word (0x28) is the edge flag of interrupt 16+k, and even bits read 0. The trigger-low word (0x24) shows flags 0–15 the same way and ignores writes.
- R10: A pending read returns the latched pending bits ORed with `line_level` for every interrupt whose edge flag is 0.
- R11: A 0-to-1 change of `line_level[i]` with edge flag i set latches pending bit i one clock later. A level-triggered line never latches.
- R12: The identification word (0x2C) reads `ID_VALUE` and ignores writes. Reserved offsets, misaligned word accesses and byte accesses outside 0x40–0x5F read 0, ignore writes and never signal an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | 1 removes the secure/non-secure split |
| line_level | input | 32 | Live interrupt input levels |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_secure | input | 1 | 1 secure access |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access accepted (always 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest state to reach is the one where a latched pending bit and a live level-triggered line overlap while a non-secure view masks part of the word. The stimulus first programs the group word so that only the low half is non-secure. It then sets the trigger flags and the pending bits through both aliases. Only after that does it raise edge-triggered and level-triggered lines together, and it reads pending while they are high, again after they fall, and from both security views. The shifted priority view is checked in both directions by writing through the non-secure path and reading back through the secure one.

// File: rtl/irqcfg_pkg.sv
package irqcfg_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_GROUP,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_AC_SET,
        SEL_AC_CLR,
        SEL_GMOD,
        SEL_SGIACC,
        SEL_TRIG_LO,
        SEL_TRIG_HI,
        SEL_IDENT,
        SEL_PRIO
    } reg_sel_e;

    localparam int OFS_GROUP   = 'h00;
    localparam int OFS_EN_SET  = 'h04;
    localparam int OFS_EN_CLR  = 'h08;
    localparam int OFS_PD_SET  = 'h0C;
    localparam int OFS_PD_CLR  = 'h10;
    localparam int OFS_AC_SET  = 'h14;
    localparam int OFS_AC_CLR  = 'h18;
    localparam int OFS_GMOD    = 'h1C;
    localparam int OFS_SGIACC  = 'h20;
    localparam int OFS_TRIG_LO = 'h24;
    localparam int OFS_TRIG_HI = 'h28;
    localparam int OFS_IDENT   = 'h2C;
    localparam int PRIO_BASE   = 'h40;

    localparam int BUS_W       = 32;
    localparam int LANES       = BUS_W / 8;

endpackage

// File: rtl/irqcfg_decode.sv
module irqcfg_decode
    import irqcfg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_IRQ = 32,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int WIDX_W = IDX_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_byte,
    output reg_sel_e          sel,
    output logic [LANES-1:0]  lane_en,
    output logic [WIDX_W-1:0] word_idx
);

    localparam logic [ADDR_W-1:0] PRIO_LO = ADDR_W'(PRIO_BASE);
    localparam logic [ADDR_W-1:0] PRIO_HI = ADDR_W'(PRIO_BASE + NUM_IRQ);

    logic in_prio;
    logic aligned;

    always_comb begin
        in_prio  = (addr >= PRIO_LO) && (addr < PRIO_HI);
        aligned  = (addr[1:0] == 2'b00);
        word_idx = addr[IDX_W-1:2];
        lane_en  = '0;
        sel      = SEL_NONE;
        if (in_prio) begin
            if (is_byte) begin
                sel     = SEL_PRIO;
                lane_en = LANES'(1) << addr[1:0];
            end else if (aligned) begin
                sel     = SEL_PRIO;
                lane_en = '1;
            end
        end else if (!is_byte && aligned) begin
            case (addr)
                ADDR_W'(OFS_GROUP):   sel = SEL_GROUP;
                ADDR_W'(OFS_EN_SET):  sel = SEL_EN_SET;
                ADDR_W'(OFS_EN_CLR):  sel = SEL_EN_CLR;
                ADDR_W'(OFS_PD_SET):  sel = SEL_PD_SET;
                ADDR_W'(OFS_PD_CLR):  sel = SEL_PD_CLR;
                ADDR_W'(OFS_AC_SET):  sel = SEL_AC_SET;
                ADDR_W'(OFS_AC_CLR):  sel = SEL_AC_CLR;
                ADDR_W'(OFS_GMOD):    sel = SEL_GMOD;
                ADDR_W'(OFS_SGIACC):  sel = SEL_SGIACC;
                ADDR_W'(OFS_TRIG_LO): sel = SEL_TRIG_LO;
                ADDR_W'(OFS_TRIG_HI): sel = SEL_TRIG_HI;
                ADDR_W'(OFS_IDENT):   sel = SEL_IDENT;
                default:              sel = SEL_NONE;
            endcase
        end
    end

    // R12: a byte access outside the priority window decodes to nothing
    always_comb begin
        if (is_byte && !in_prio) begin
            a_r12_byte_reserved: assert (sel == SEL_NONE && lane_en == '0);
        end
    end

endmodule

// File: rtl/irqcfg_prio_lane.sv
module irqcfg_prio_lane #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] stored,
    input  logic [PRIO_W-1:0] wr_byte,
    input  logic              restricted,
    input  logic              grp,
    output logic [PRIO_W-1:0] rd_view,
    output logic              wr_ok,
    output logic [PRIO_W-1:0] wr_view
);

    always_comb begin
        wr_ok = !restricted || grp;
        if (!restricted) begin
            rd_view = stored;
            wr_view = wr_byte;
        end else begin
            rd_view = grp ? {stored[PRIO_W-2:0], 1'b0} : '0;
            wr_view = {1'b1, wr_byte[PRIO_W-1:1]};
        end
    end

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irqcfg_pkg::*;
#(
    parameter int          NUM_IRQ  = 32,
    parameter int          ADDR_W   = 8,
    parameter int          PRIO_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h4A11_0C03
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_disable,
    input  logic [NUM_IRQ-1:0] line_level,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_byte,
    input  logic               req_secure,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]   req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [BUS_W-1:0]   rsp_rdata
);

    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int WIDX_W  = IDX_W - 2;
    localparam int HALF    = NUM_IRQ / 2;
    localparam int ACC_W   = 2 * HALF;

    typedef struct packed {
        logic [NUM_IRQ-1:0]             grp;
        logic [NUM_IRQ-1:0]             en;
        logic [NUM_IRQ-1:0]             pend;
        logic [NUM_IRQ-1:0]             act;
        logic [NUM_IRQ-1:0]             gmod;
        logic [NUM_IRQ-1:0]             edg;
        logic [NUM_IRQ-1:0]             lvl;
        logic [ACC_W-1:0]               acc;
        logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
        logic                           rsp_v;
        logic [BUS_W-1:0]               rdata;
    } state_t;

    state_t state_d, state_q;

    reg_sel_e                      sel;
    logic [LANES-1:0]              lane_en;
    logic [WIDX_W-1:0]             word_idx;
    logic                          restricted;
    logic                          full_priv;
    logic [NUM_IRQ-1:0]            acc_mask;
    logic [NUM_IRQ-1:0]            wmask;
    logic [NUM_IRQ-1:0]            rise;
    logic [LANES-1:0][PRIO_W-1:0]  lane_rd;
    logic [LANES-1:0][PRIO_W-1:0]  lane_wv;
    logic [LANES-1:0]              lane_ok;
    logic [BUS_W-1:0]              rd_word;
    logic                          do_wr;
    logic [HALF-1:0]               trig_wr;
    logic [NUM_IRQ-1:0]            pend_view;

    irqcfg_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_IRQ (NUM_IRQ)
    ) u_decode (
        .addr     (req_addr),
        .is_byte  (req_byte),
        .sel      (sel),
        .lane_en  (lane_en),
        .word_idx (word_idx)
    );

    assign restricted = !req_secure && !sec_disable;
    assign full_priv  = req_secure && !sec_disable;
    assign acc_mask   = restricted ? state_q.grp : '1;
    assign req_ready  = 1'b1;
    assign rsp_valid  = state_q.rsp_v;
    assign rsp_rdata  = state_q.rdata;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0] irq_idx;
        assign irq_idx = {word_idx, 2'(k)};
        irqcfg_prio_lane #(
            .PRIO_W (PRIO_W)
        ) u_lane (
            .stored     (state_q.prio[irq_idx]),
            .wr_byte    (req_byte ? req_wdata[PRIO_W-1:0] : req_wdata[k*8 +: PRIO_W]),
            .restricted (restricted),
            .grp        (state_q.grp[irq_idx]),
            .rd_view    (lane_rd[k]),
            .wr_ok      (lane_ok[k]),
            .wr_view    (lane_wv[k])
        );
    end

    for (genvar k = 0; k < HALF; k++) begin : g_trig_pack
        assign trig_wr[k] = req_wdata[2*k+1];
    end

    function automatic logic [BUS_W-1:0] spread(input logic [HALF-1:0] flags);
        logic [BUS_W-1:0] w;
        w = '0;
        for (int k = 0; k < HALF; k++) begin
            w[2*k+1] = flags[k];
        end
        return w;
    endfunction

    // Read path
    always_comb begin
        pend_view = state_q.pend | (line_level & ~state_q.edg);
        rd_word   = '0;
        case (sel)
            SEL_GROUP:              rd_word = restricted ? '0 : BUS_W'(state_q.grp);
            SEL_EN_SET, SEL_EN_CLR: rd_word = BUS_W'(state_q.en & acc_mask);
            SEL_PD_SET, SEL_PD_CLR: rd_word = BUS_W'(pend_view & acc_mask);
            SEL_AC_SET, SEL_AC_CLR: rd_word = BUS_W'(state_q.act & acc_mask);
            SEL_GMOD:               rd_word = full_priv ? BUS_W'(state_q.gmod) : '0;
            SEL_SGIACC:             rd_word = full_priv ? BUS_W'(state_q.acc) : '0;
            SEL_TRIG_LO:            rd_word = spread(state_q.edg[HALF-1:0] & acc_mask[HALF-1:0]);
            SEL_TRIG_HI:            rd_word = spread(state_q.edg[NUM_IRQ-1:HALF] & acc_mask[NUM_IRQ-1:HALF]);
            SEL_IDENT:              rd_word = ID_VALUE;
            SEL_PRIO:               rd_word = req_byte ? BUS_W'(lane_rd[req_addr[1:0]]) : BUS_W'(lane_rd);
            default:                rd_word = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        do_wr       = req_valid && req_write;
        wmask       = req_wdata[NUM_IRQ-1:0] & acc_mask;
        rise        = line_level & ~state_q.lvl & state_q.edg;
        state_d.lvl = line_level;

        if (do_wr) begin
            case (sel)
                SEL_GROUP:   if (!restricted) state_d.grp = req_wdata[NUM_IRQ-1:0];
                SEL_EN_SET:  state_d.en   = state_q.en | wmask;
                SEL_EN_CLR:  state_d.en   = state_q.en & ~wmask;
                SEL_PD_SET:  state_d.pend = state_q.pend | wmask;
                SEL_PD_CLR:  state_d.pend = state_q.pend & ~wmask;
                SEL_AC_SET:  state_d.act  = state_q.act | wmask;
                SEL_AC_CLR:  state_d.act  = state_q.act & ~wmask;
                SEL_GMOD:    if (full_priv) state_d.gmod = req_wdata[NUM_IRQ-1:0];
                SEL_SGIACC:  if (full_priv) state_d.acc  = req_wdata[ACC_W-1:0];
                SEL_TRIG_HI: state_d.edg[NUM_IRQ-1:HALF] =
                                 (state_q.edg[NUM_IRQ-1:HALF] & ~acc_mask[NUM_IRQ-1:HALF]) |
                                 (trig_wr & acc_mask[NUM_IRQ-1:HALF]);
                SEL_PRIO: begin
                    for (int k = 0; k < LANES; k++) begin
                        if (lane_en[k] && lane_ok[k]) begin
                            state_d.prio[{word_idx, 2'(k)}] = lane_wv[k];
                        end
                    end
                end
                default: ;
            endcase
        end

        // hardware edge latch is applied after any software update
        state_d.pend  = state_d.pend | rise;
        state_d.rsp_v = req_valid && !req_write;
        state_d.rdata = (req_valid && !req_write) ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    a_r2_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    a_r4_masked_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && !sec_disable)
        |=> (((state_q.en ^ $past(state_q.en)) & ~$past(state_q.grp)) == '0));

    a_r5_group_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && !sec_disable) |=> $stable(state_q.grp));

    a_r6_gmod_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (sec_disable || !req_secure)) |=> $stable(state_q.gmod));

    a_r11_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((state_q.pend & $past(rise)) == $past(rise)));

endmodule

// File: tb/tb_irq_cfg_bank.sv
module tb_irq_cfg_bank;

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic        byt;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 56;
    localparam logic [31:0] IDV = 32'h4A11_0C03;

    // columns: wr, sec, byte, addr, wdata, expected, requirement
    localparam vec_t VEC [NV] = '{
        {1'b0,1'b1,1'b0,8'h00,32'h0,        32'h0,        4'd1},  // R1 group
        {1'b0,1'b1,1'b0,8'h04,32'h0,        32'h0,        4'd1},  // R1 enable
        {1'b1,1'b1,1'b0,8'h00,32'h0000FFFF, 32'h0,        4'd5},
        {1'b0,1'b1,1'b0,8'h00,32'h0,        32'h0000FFFF, 4'd5},  // R5
        {1'b1,1'b1,1'b0,8'h04,32'hF0F0F0F0, 32'h0,        4'd3},
        {1'b1,1'b1,1'b0,8'h04,32'h0000000F, 32'h0,        4'd3},
        {1'b0,1'b1,1'b0,8'h08,32'h0,        32'hF0F0F0FF, 4'd3},  // R3 clear alias read
        {1'b1,1'b1,1'b0,8'h08,32'h000000F0, 32'h0,        4'd3},
        {1'b0,1'b1,1'b0,8'h04,32'h0,        32'hF0F0F00F, 4'd3},  // R3
        {1'b0,1'b0,1'b0,8'h04,32'h0,        32'h0000F00F, 4'd4},  // R4
        {1'b1,1'b0,1'b0,8'h08,32'hFFFFFFFF, 32'h0,        4'd4},
        {1'b0,1'b1,1'b0,8'h04,32'h0,        32'hF0F00000, 4'd4},  // R4
        {1'b1,1'b0,1'b0,8'h0C,32'hFFFFFFFF, 32'h0,        4'd4},
        {1'b0,1'b1,1'b0,8'h0C,32'h0,        32'h0000FFFF, 4'd4},  // R4
        {1'b1,1'b1,1'b0,8'h10,32'h0000FF00, 32'h0,        4'd3},
        {1'b0,1'b0,1'b0,8'h10,32'h0,        32'h000000FF, 4'd3},  // R3
        {1'b1,1'b1,1'b0,8'h14,32'h80000001, 32'h0,        4'd3},
        {1'b0,1'b0,1'b0,8'h18,32'h0,        32'h00000001, 4'd4},  // R4
        {1'b1,1'b0,1'b0,8'h00,32'hFFFFFFFF, 32'h0,        4'd5},
        {1'b0,1'b0,1'b0,8'h00,32'h0,        32'h0,        4'd5},  // R5
        {1'b0,1'b1,1'b0,8'h00,32'h0,        32'h0000FFFF, 4'd5},  // R5
        {1'b1,1'b1,1'b0,8'h1C,32'h12345678, 32'h0,        4'd6},
        {1'b0,1'b1,1'b0,8'h1C,32'h0,        32'h12345678, 4'd6},  // R6
        {1'b0,1'b0,1'b0,8'h1C,32'h0,        32'h0,        4'd6},  // R6
        {1'b1,1'b0,1'b0,8'h1C,32'hFFFFFFFF, 32'h0,        4'd6},
        {1'b0,1'b1,1'b0,8'h1C,32'h0,        32'h12345678, 4'd6},  // R6
        {1'b1,1'b1,1'b0,8'h20,32'hA5A5A5A5, 32'h0,        4'd6},
        {1'b0,1'b1,1'b0,8'h20,32'h0,        32'hA5A5A5A5, 4'd6},  // R6
        {1'b0,1'b0,1'b0,8'h20,32'h0,        32'h0,        4'd6},  // R6
        {1'b1,1'b1,1'b0,8'h40,32'h44332211, 32'h0,        4'd7},
        {1'b0,1'b1,1'b0,8'h40,32'h0,        32'h44332211, 4'd7},  // R7
        {1'b0,1'b1,1'b1,8'h42,32'h0,        32'h00000033, 4'd7},  // R7 byte read
        {1'b0,1'b0,1'b0,8'h40,32'h0,        32'h88664422, 4'd8},  // R8 shifted view
        {1'b1,1'b0,1'b1,8'h41,32'h000000FE, 32'h0,        4'd8},
        {1'b0,1'b1,1'b1,8'h41,32'h0,        32'h000000FF, 4'd8},  // R8 forced top bit
        {1'b1,1'b1,1'b0,8'h50,32'hDDCCBBAA, 32'h0,        4'd7},
        {1'b1,1'b0,1'b0,8'h50,32'h11111111, 32'h0,        4'd8},
        {1'b0,1'b1,1'b0,8'h50,32'h0,        32'hDDCCBBAA, 4'd8},  // R8 group-0 write ignored
        {1'b0,1'b0,1'b0,8'h50,32'h0,        32'h0,        4'd8},  // R8 group-0 reads 0
        {1'b1,1'b1,1'b1,8'h5F,32'h0000007E, 32'h0,        4'd7},
        {1'b0,1'b1,1'b0,8'h5C,32'h0,        32'h7E000000, 4'd7},  // R7 lane order
        {1'b1,1'b1,1'b0,8'h28,32'hAAAAAAAA, 32'h0,        4'd9},
        {1'b0,1'b1,1'b0,8'h28,32'h0,        32'hAAAAAAAA, 4'd9},  // R9
        {1'b1,1'b1,1'b0,8'h28,32'h00000008, 32'h0,        4'd9},
        {1'b0,1'b1,1'b0,8'h28,32'h0,        32'h00000008, 4'd9},  // R9
        {1'b1,1'b1,1'b0,8'h24,32'hFFFFFFFF, 32'h0,        4'd9},
        {1'b0,1'b1,1'b0,8'h24,32'h0,        32'h0,        4'd9},  // R9 low word ignores writes
        {1'b0,1'b0,1'b0,8'h28,32'h0,        32'h0,        4'd4},  // R4 trigger masked
        {1'b0,1'b1,1'b0,8'h2C,32'h0,        IDV,          4'd12}, // R12
        {1'b1,1'b1,1'b0,8'h2C,32'h0,        32'h0,        4'd12},
        {1'b0,1'b1,1'b0,8'h2C,32'h0,        IDV,          4'd12}, // R12
        {1'b1,1'b1,1'b0,8'h30,32'hFFFFFFFF, 32'h0,        4'd12},
        {1'b0,1'b1,1'b0,8'h30,32'h0,        32'h0,        4'd12}, // R12 reserved
        {1'b1,1'b1,1'b1,8'h04,32'h000000FF, 32'h0,        4'd12},
        {1'b0,1'b1,1'b0,8'h04,32'h0,        32'hF0F00000, 4'd12}, // R12 byte outside window ignored
        {1'b0,1'b1,1'b1,8'h04,32'h0,        32'h0,        4'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_disable = 1'b0;
    logic [31:0] line_level = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_byte = 1'b0;
    logic        req_secure = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_cfg_bank dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_disable (sec_disable),
        .line_level  (line_level),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_byte    (req_byte),
        .req_secure  (req_secure),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic sec, input logic byt,
                          input logic [7:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic v);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_secure = sec;
        req_byte   = byt;
        req_addr   = addr;
        req_wdata  = wd;
        @(negedge clk);
        rd = rsp_rdata;
        v  = rsp_valid;
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic sec, input logic [7:0] addr,
                          input logic [31:0] exp, input string rq);
        logic [31:0] d;
        logic v;
        access(1'b0, sec, 1'b0, addr, 32'h0, d, v);
        chk(d, exp, rq);
    endtask

    task automatic wr_do(input logic sec, input logic [7:0] addr, input logic [31:0] wd);
        logic [31:0] d;
        logic v;
        access(1'b1, sec, 1'b0, addr, wd, d, v);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({31'b0, rsp_valid}, 32'h0, "R1 rsp_valid after reset");
        chk({31'b0, req_ready}, 32'h1, "R2 req_ready");

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].sec, VEC[i].byt, VEC[i].addr, VEC[i].wd, d, v);
            chk({31'b0, v}, {31'b0, !VEC[i].wr}, $sformatf("R2 rsp_valid vec %0d", i));
            if (!VEC[i].wr) begin
                chk(d, VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].rq, i));
            end
        end

        // R10: level-triggered lines show through pending reads
        line_level = 32'h0000_0300;
        rd_chk(1'b1, 8'h0C, 32'h0000_03FF, "R10 level lines");
        line_level = 32'h0;
        rd_chk(1'b1, 8'h0C, 32'h0000_00FF, "R11 level not latched");

        // R11: edge flag on 17 latches, 16 stays level-only
        line_level = 32'h0003_0000;
        rd_chk(1'b1, 8'h0C, 32'h0003_00FF, "R10 R11 mixed lines high");
        line_level = 32'h0;
        rd_chk(1'b1, 8'h10, 32'h0002_00FF, "R11 edge latched");
        rd_chk(1'b0, 8'h0C, 32'h0000_00FF, "R4 pending masked");

        // security disabled
        sec_disable = 1'b1;
        rd_chk(1'b0, 8'h00, 32'h0000_FFFF, "R5 group visible when disabled");
        rd_chk(1'b1, 8'h1C, 32'h0,         "R6 gmod hidden when disabled");
        wr_do(1'b0, 8'h00, 32'hFFFF_FFFF);
        rd_chk(1'b0, 8'h00, 32'hFFFF_FFFF, "R5 group writable when disabled");
        rd_chk(1'b0, 8'h40, 32'h4433_FF11, "R8 raw view when disabled");
        rd_chk(1'b0, 8'h04, 32'hF0F0_0000, "R4 no mask when disabled");
        wr_do(1'b0, 8'h10, 32'hFFFF_FFFF);
        rd_chk(1'b1, 8'h0C, 32'h0,         "R3 clear alias all");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule